// File: doc/BRIEF.md
# Display Command/Data Serial Transmitter

This block is a transmit-only serial master that feeds a small display controller. Bytes arrive on a valid/ready input. Each byte carries a flag that marks it as a command or as pixel/parameter data. The block shifts each byte out on a serial clock, an active-low select and a single data line. A separate command/data output is also provided.

Two framings are available. In the 9-bit framing no side signal is used: the flag travels as the first bit of the frame. In the 8-bit framing only the payload is shifted, and the flag is presented on the command/data output for the whole time the select is low. A two-bit mode input picks the clock idle level and the sampling phase. A divider input sets the clock rate to `clk / (2*(cfg_div+1))`.

Bytes offered back to back are sent inside one select window with a continuous clock. The 8-bit framing is the exception: a flag change closes the window first. There is no acknowledgment, and a byte is complete once its last clock edge has been produced.

Top module: `dspi_tx`

## Requirements
- R1: With `cfg_four_wire`=0 each frame is 9 bits: the flag bit first (0 = command, 1 = data), then the 8 payload bits MSB first; `dc_out` stays low.
- R2: With `cfg_four_wire`=1 each frame is the 8 payload bits MSB first, and `dc_out` equals the flag (1 = data, 0 = command) while the frame is selected.
- R3: `dc_out` is updated when a byte is accepted from idle, before `cs_n` falls, and does not change while `cs_n` is low.
- R4: `cfg_mode[1]` is the clock polarity: whenever `cs_n` is high, `sclk` rests at that level.
- R5: `cfg_mode[0]` is the phase. At 0, the first bit is on `sdo` before the first clock edge; bits are sampled on leading edges and change on trailing edges. At 1, bits change on leading edges and are sampled on trailing edges. `sclk` toggles only while `cs_n` is low.
- R6: Each half clock period lasts `cfg_div+1` cycles. `cs_n` falls one half period before the first edge and rises one half period after the last edge.
- R7: `done` is a one-cycle pulse, raised in the cycle of the last clock edge of each byte, and there is exactly one per byte.
- R8: `in_ready` is high while idle. At the last edge of a byte, a waiting byte is taken at once and `cs_n` stays low, provided that in the 8-bit framing its flag equals the current one. Otherwise `cs_n` rises before the next byte.
- R9: `cfg_four_wire`, `cfg_mode` and `cfg_div` are captured only when a byte is accepted from idle; changing them during a burst has no effect on that burst.
- R10: After reset `cs_n`=1, `sclk`=0, `sdo`=0, `dc_out`=0, `done`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte taken when high together with in_valid |
| in_byte | input | DATA_W | Payload byte |
| in_is_data | input | 1 | 1 = data, 0 = command |
| cfg_four_wire | input | 1 | 0 = 9-bit in-band flag framing, 1 = 8-bit framing with dc_out |
| cfg_mode | input | 2 | bit 1 clock idle level, bit 0 sampling phase |
| cfg_div | input | DIV_W | Half-period length minus one, in clk cycles |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low select |
| sdo | output | 1 | Serial data |
| dc_out | output | 1 | Command/data marker in 8-bit framing |
| done | output | 1 | One-cycle pulse per completed byte |

## Verification
Random payloads and random flags are sent through every pairing of framing and clock mode with small random divider values. This shows whether the bit order, the in-band flag and the sampling edge are all correct at once. The 8-bit bursts with a single flag and with alternating flags tell a single select window apart from a window split at each flag change. A burst with idle gaps tells the merge rule apart from simply leaving the select low. A burst that changes all configuration inputs mid-transfer tells latched settings apart from live ones.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_POST  = 2'd3
  } dspi_state_e;
endpackage

// File: rtl/dspi_rst_sync.sv
module dspi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dspi_clkdiv.sv
module dspi_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div)); // R6
endmodule

// File: rtl/dspi_shifter.sv
module dspi_shifter #(
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               emit,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame,
  output logic               sdo
);
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               sdo_q, sdo_d;

  always_comb begin
    sr_d  = sr_q;
    sdo_d = sdo_q;
    if (load) begin
      if (emit) begin
        sdo_d = frame[FRAME_W-1];
        sr_d  = {frame[FRAME_W-2:0], 1'b0};
      end else begin
        sr_d  = frame;
      end
    end else if (shift) begin
      sdo_d = sr_q[FRAME_W-1];
      sr_d  = {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo = sdo_q;

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R5
endmodule

// File: rtl/dspi_ctrl.sv
module dspi_ctrl
  import dspi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  localparam int FRAME_W = DATA_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_is_data,
  input  logic [DATA_W-1:0]  in_byte,
  output logic               in_ready,
  input  logic               cfg_four_wire,
  input  logic [1:0]         cfg_mode,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               tick,
  output logic               run,
  output logic [DIV_W-1:0]   div_lat,
  output logic               ld,
  output logic               ld_emit,
  output logic               sh,
  output logic [FRAME_W-1:0] frame,
  output logic               sclk,
  output logic               cs_n,
  output logic               dc_out,
  output logic               done
);
  localparam int EDGE_W = $clog2(2 * FRAME_W);
  localparam logic [EDGE_W-1:0] LAST_SHORT = EDGE_W'(2 * DATA_W - 1);
  localparam logic [EDGE_W-1:0] LAST_LONG  = EDGE_W'(2 * FRAME_W - 1);

  dspi_state_e       state_q, state_d;
  logic              four_q, four_d;
  logic              cpol_q, cpol_d;
  logic              cpha_q, cpha_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              sclk_q, sclk_d;
  logic              cs_n_q, cs_n_d;
  logic              dc_q, dc_d;
  logic              done_q, done_d;

  logic last_edge, end_tick, flag_ok, accept, eff_four, eff_cpha;

  assign last_edge = (edge_q == (four_q ? LAST_SHORT : LAST_LONG));
  assign end_tick  = (state_q == ST_SHIFT) && tick && last_edge;
  assign flag_ok   = !four_q || (in_is_data == dc_q);
  assign in_ready  = (state_q == ST_IDLE) || (end_tick && flag_ok);
  assign accept    = in_valid && in_ready;
  assign eff_four  = (state_q == ST_IDLE) ? cfg_four_wire : four_q;
  assign eff_cpha  = (state_q == ST_IDLE) ? cfg_mode[0]   : cpha_q;

  assign frame   = eff_four ? {in_byte, 1'b0} : {in_is_data, in_byte};
  assign ld      = accept;
  assign ld_emit = !eff_cpha;
  assign sh      = (state_q == ST_SHIFT) && tick &&
                   (cpha_q ? !edge_q[0] : (edge_q[0] && !last_edge));
  assign run     = (state_q != ST_IDLE);
  assign div_lat = div_q;

  always_comb begin
    state_d = state_q;
    four_d  = four_q;
    cpol_d  = cpol_q;
    cpha_d  = cpha_q;
    div_d   = div_q;
    edge_d  = edge_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    dc_d    = dc_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sclk_d = cfg_mode[1];
        if (accept) begin
          state_d = ST_PRE;
          four_d  = cfg_four_wire;
          cpol_d  = cfg_mode[1];
          cpha_d  = cfg_mode[0];
          div_d   = cfg_div;
          dc_d    = cfg_four_wire && in_is_data;
        end
      end
      ST_PRE: begin
        if (tick) begin
          state_d = ST_SHIFT;
          cs_n_d  = 1'b0;
          edge_d  = '0;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          sclk_d = !sclk_q;
          edge_d = edge_q + 1'b1;
          if (last_edge) begin
            done_d = 1'b1;
            edge_d = '0;
            if (!accept) state_d = ST_POST;
          end
        end
      end
      ST_POST: begin
        if (tick) begin
          state_d = ST_IDLE;
          cs_n_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      four_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      div_q   <= '0;
      edge_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      dc_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      four_q  <= four_d;
      cpol_q  <= cpol_d;
      cpha_q  <= cpha_d;
      div_q   <= div_d;
      edge_q  <= edge_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      dc_q    <= dc_d;
      done_q  <= done_d;
    end
  end

  assign sclk   = sclk_q;
  assign cs_n   = cs_n_q;
  assign dc_out = dc_q;
  assign done   = done_q;

  AST_CLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk_q) && ($past(state_q) != ST_IDLE)) |-> !cs_n_q); // R5
  AST_DC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && !$past(cs_n_q)) |-> $stable(dc_q)); // R3
  AST_PRE_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |-> (sclk_q == cpol_q)); // R4
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_IDLE) |->
      ($stable(cpol_q) && $stable(cpha_q) && $stable(four_q) && $stable(div_q))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= LAST_LONG); // R1
endmodule

// File: rtl/dspi_tx.sv
module dspi_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_is_data,
  input  logic              cfg_four_wire,
  input  logic [1:0]        cfg_mode,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              sclk,
  output logic              cs_n,
  output logic              sdo,
  output logic              dc_out,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 1;

  logic               rst_sync_n;
  logic               tick, run, ld, ld_emit, sh;
  logic [DIV_W-1:0]   div_lat;
  logic [FRAME_W-1:0] frame;

  dspi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dspi_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .div   (div_lat),
    .tick  (tick)
  );

  dspi_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .in_valid      (in_valid),
    .in_is_data    (in_is_data),
    .in_byte       (in_byte),
    .in_ready      (in_ready),
    .cfg_four_wire (cfg_four_wire),
    .cfg_mode      (cfg_mode),
    .cfg_div       (cfg_div),
    .tick          (tick),
    .run           (run),
    .div_lat       (div_lat),
    .ld            (ld),
    .ld_emit       (ld_emit),
    .sh            (sh),
    .frame         (frame),
    .sclk          (sclk),
    .cs_n          (cs_n),
    .dc_out        (dc_out),
    .done          (done)
  );

  dspi_shifter #(.FRAME_W(FRAME_W)) u_sh (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (ld),
    .emit  (ld_emit),
    .shift (sh),
    .frame (frame),
    .sdo   (sdo)
  );
endmodule

// File: tb/dspi_tx_tb_top.sv
module dspi_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_is_data, cfg_four_wire;
  logic [7:0] in_byte, cfg_div;
  logic [1:0] cfg_mode;
  logic       sclk, cs_n, sdo, dc_out, done;

  always #5 clk = ~clk;

  dspi_tx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .cfg_four_wire(cfg_four_wire),
    .cfg_mode(cfg_mode), .cfg_div(cfg_div), .sclk(sclk), .cs_n(cs_n),
    .sdo(sdo), .dc_out(dc_out), .done(done)
  );

  int n_chk = 0, n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor configuration and results
  bit   mon_en = 0;
  bit   mon_cpol, mon_cpha;
  int   mon_nbits, mon_div;
  int   cyc = 0, t_cs = 0, t_edge = 0;
  bit   first_edge;
  logic sclk_p = 1'b0, cs_p = 1'b1, dc_at_cs = 1'b0;
  int   v_timing, v_idle, v_dc, v_edge_cs, v_done_bits, wins, dones;
  logic [8:0] cap;
  int   ncap;
  logic [8:0] rx_frame[$];
  logic       rx_dc[$];

  always @(negedge clk) begin
    cyc++;
    if (rst_n && mon_en) begin
      if (cs_p && !cs_n) begin
        wins++; t_cs = cyc; first_edge = 1; dc_at_cs = dc_out;
      end
      if (!cs_n && !cs_p && dc_out !== dc_at_cs) v_dc++;
      if (sclk !== sclk_p) begin
        if (cs_n) v_edge_cs++;
        else begin
          if ((first_edge ? cyc - t_cs : cyc - t_edge) != mon_div + 1) v_timing++;
          first_edge = 0;
          t_edge = cyc;
          if ((sclk_p == mon_cpol) == !mon_cpha) begin
            cap = {cap[7:0], sdo};
            ncap++;
          end
        end
      end
      if (cs_n && sclk !== mon_cpol) v_idle++;
      if (!cs_p && cs_n && (cyc - t_edge != mon_div + 1)) v_timing++;
      if (done) begin
        dones++;
        if (ncap != mon_nbits) v_done_bits++;
        rx_frame.push_back(cap);
        rx_dc.push_back(dc_out);
        ncap = 0; cap = '0;
      end
    end
    sclk_p = sclk;
    cs_p   = cs_n;
  end

  logic [7:0] tx_b[$];
  logic       tx_f[$];

  task automatic send(input logic [7:0] b, input logic f);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_data = f;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_quiet(input int div);
    repeat (2 * (div + 1) * 12 + 10) @(negedge clk);
    while (!cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input string name, input bit four, input logic [1:0] mode,
                          input int div, input bit gap, input bit disturb);
    int exp_wins;
    mon_en = 0;
    @(negedge clk);
    cfg_four_wire = four; cfg_mode = mode; cfg_div = 8'(div);
    repeat (3) @(negedge clk);
    v_timing = 0; v_idle = 0; v_dc = 0; v_edge_cs = 0; v_done_bits = 0;
    wins = 0; dones = 0; ncap = 0; cap = '0;
    rx_frame.delete(); rx_dc.delete();
    mon_cpol = mode[1]; mon_cpha = mode[0]; mon_div = div;
    mon_nbits = four ? 8 : 9;
    mon_en = 1;
    fork
      begin
        for (int i = 0; i < tx_b.size(); i++) begin
          send(tx_b[i], tx_f[i]);
          if (gap) wait_quiet(div);
        end
      end
      begin
        if (disturb) begin
          while (cs_n) @(negedge clk);
          repeat (10) @(negedge clk);
          cfg_mode = ~mode; cfg_four_wire = ~four; cfg_div = 8'd0;
          repeat (20) @(negedge clk);
          cfg_mode = mode; cfg_four_wire = four; cfg_div = 8'(div);
        end
      end
    join
    wait_quiet(div);
    exp_wins = 1;
    if (gap) exp_wins = tx_b.size();
    else if (four)
      for (int i = 1; i < tx_f.size(); i++) if (tx_f[i] != tx_f[i-1]) exp_wins++;
    check(rx_frame.size() == tx_b.size(), "R7", {name, " frame count"}, rx_frame.size(), tx_b.size());
    check(dones == tx_b.size(), "R7", {name, " done pulses"}, dones, tx_b.size());
    check(v_done_bits == 0, "R7", {name, " done not at last bit"}, v_done_bits, 0);
    for (int i = 0; i < rx_frame.size() && i < tx_b.size(); i++) begin
      if (four) begin
        check(rx_frame[i][7:0] == tx_b[i], "R2/R5", {name, " payload"}, rx_frame[i][7:0], tx_b[i]);
        check(rx_dc[i] == tx_f[i], "R2", {name, " dc_out"}, rx_dc[i], tx_f[i]);
      end else begin
        check(rx_frame[i] == {tx_f[i], tx_b[i]}, "R1/R5", {name, " frame"}, rx_frame[i], {tx_f[i], tx_b[i]});
        check(rx_dc[i] == 1'b0, "R1", {name, " dc_out low"}, rx_dc[i], 0);
      end
    end
    check(v_timing == 0, "R6", {name, " half-period timing"}, v_timing, 0);
    check(v_idle == 0, "R4", {name, " idle level"}, v_idle, 0);
    check(v_edge_cs == 0, "R5", {name, " edge while deselected"}, v_edge_cs, 0);
    check(v_dc == 0, "R3", {name, " dc_out stability"}, v_dc, 0);
    check(wins == exp_wins, "R8", {name, " select windows"}, wins, exp_wins);
    if (disturb) check(v_timing == 0 && wins == 1, "R9", {name, " latched config"}, wins, 1);
    mon_en = 0;
  endtask

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_is_data = 1'b0;
    cfg_four_wire = 1'b0; cfg_mode = 2'b00; cfg_div = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(cs_n == 1'b1, "R10", "cs_n", cs_n, 1);
    check(sclk == 1'b0, "R10", "sclk", sclk, 0);
    check(sdo == 1'b0, "R10", "sdo", sdo, 0);
    check(dc_out == 1'b0, "R10", "dc_out", dc_out, 0);
    check(done == 1'b0, "R10", "done", done, 0);
    check(in_ready == 1'b1, "R10/R8", "in_ready idle", in_ready, 1);

    // random payloads across every framing and mode
    for (int c = 0; c < 8; c++) begin
      tx_b.delete(); tx_f.delete();
      for (int i = 0; i < 6; i++) begin
        tx_b.push_back(8'($urandom));
        tx_f.push_back(1'($urandom));
      end
      run_case($sformatf("rand cfg%0d", c), c[2], c[1:0], $urandom_range(0, 3), 1'b0, 1'b0);
    end

    // 8-bit framing, one flag, corner payloads: single window
    tx_b = '{8'h00, 8'hFF, 8'hA5, 8'h5A}; tx_f = '{1'b1, 1'b1, 1'b1, 1'b1};
    run_case("same flag", 1'b1, 2'b11, 0, 1'b0, 1'b0);

    // 8-bit framing, alternating flags: window per byte
    tx_b = '{8'h2C, 8'h81, 8'h3A, 8'h7E}; tx_f = '{1'b0, 1'b1, 1'b0, 1'b1};
    run_case("alt flag", 1'b1, 2'b00, 1, 1'b0, 1'b0);

    // 9-bit framing with idle gaps: window per byte
    tx_b = '{8'h11, 8'hEE, 8'h80}; tx_f = '{1'b0, 1'b1, 1'b0};
    run_case("gapped", 1'b0, 2'b10, 0, 1'b1, 1'b0);

    // configuration changed mid-burst must be ignored
    tx_b = '{8'hC3, 8'h01, 8'hFE}; tx_f = '{1'b1, 1'b0, 1'b1};
    run_case("disturb", 1'b0, 2'b01, 2, 1'b0, 1'b1);

    report();
    $finish;
  end
endmodule